// File: doc/BRIEF.md
# Dual-Clock Dual-Port Synchronous RAM

This block is a true dual-port synchronous memory of 4096 words by 9 bits. Two ports, A and B, reach the same storage at once. Each port has its own clock, clock enable, chip select, write select, address, write data and output enable. On every rising edge of its own clock, a port captures its address, write data and control inputs in registers. A captured write lands in the array at that port's next clock edge, with no further latency. A captured read is presented from the array during the cycle that follows the capture.

Port A always passes read data through an output register, so its data is one cycle later than an unregistered read. Port B uses a static mode select. When the select is high, port B is pipelined like port A. When it is low, port B is flow-through and shows the array word during the cycle after capture. Each bidirectional data bus is split into a read-data output and a drive flag. The drive flag goes high only when the port holds valid read data and its output enable is high.

When a port's clock enable is low, every register on that port keeps its value and no new access starts on that port. The storage has no handshake. A port accepts a command on every enabled edge and never applies back-pressure.

Top module: `dual_clock_ram`

## Requirements
- R1: A word written through either port is returned by a later read of the same address through either port.
- R2: On port A, a read captured at an enabled edge raises drive_a during the cycle after the next enabled edge, with the word on rdata_a, provided oe_a is high.
- R3: With pipe_b high, port B has the same two-edge read latency as port A. With pipe_b low, drive_b and rdata_b show the word during the cycle right after the capturing edge.
- R4: While a port's clock enable is low, that port starts no read or write. Its captured inputs and its output register hold their values, so a write presented with the enable low leaves the array unchanged.
- R5: A low output enable forces that port's drive flag low at once, without waiting for a clock edge. Raising it again restores the flag with no clock edge needed.
- R6: When one port writes an address in the same cycle that the other port reads it, the read returns the previous contents. A later read returns the new word.
- R7: When both ports write the same address in the same cycle, port A's data is the word kept.
- R8: During the cycle in which a port's write is presented at its output stage, that port's drive flag is low, and a pipelined port's rdata keeps its last read word.
- R9: While rst_ni is low, both drive flags are low.
- R10: Both ports may read and write different addresses in the same cycle, and each access completes as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset of port registers |
| en_a | input | 1 | Port A clock enable |
| sel_a | input | 1 | Port A chip select |
| wr_a | input | 1 | Port A write select (1 = write, 0 = read) |
| addr_a | input | AW (12) | Port A word address |
| wdata_a | input | DW (9) | Port A write data |
| oe_a | input | 1 | Port A output enable |
| rdata_a | output | DW (9) | Port A read data |
| drive_a | output | 1 | Port A data bus drive flag |
| en_b | input | 1 | Port B clock enable |
| sel_b | input | 1 | Port B chip select |
| wr_b | input | 1 | Port B write select (1 = write, 0 = read) |
| addr_b | input | AW (12) | Port B word address |
| wdata_b | input | DW (9) | Port B write data |
| oe_b | input | 1 | Port B output enable |
| pipe_b | input | 1 | Port B mode: 1 = pipelined, 0 = flow-through |
| rdata_b | output | DW (9) | Port B read data |
| drive_b | output | 1 | Port B data bus drive flag |

## Verification
The bench builds the block with AW = 4 (16 words) and DW = 9. With so few addresses, random traffic often puts both ports on the same word in the same cycle, so same-address collisions, read-during-write and double writes happen many times in every run. The full 9-bit data width is kept, so the wrong port winning a double write shows up in the data. Both clocks are tied to one net, which makes every collision land on one shared edge whose outcome is fixed by R6 and R7.

// File: rtl/dual_ram_pkg.sv
package dual_ram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ram_op_e;

  function automatic ram_op_e decode_op(input logic sel, input logic wr);
    if (!sel)    return OP_IDLE;
    else if (wr) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/dual_ram_capture.sv
module dual_ram_capture
  import dual_ram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output ram_op_e       op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wr_go
);

  // Captured command: held while the clock enable is low.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (en) begin
      op_q    <= decode_op(sel, wr);
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // Write strobe lives for exactly one port cycle, so a frozen port
  // never replays its last write into the array.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wr_go <= 1'b0;
    else         wr_go <= en && sel && wr;
  end

endmodule

// File: rtl/dual_ram_array.sv
module dual_ram_array #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          wr_go_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  input  logic          wr_go_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] word_a,
  output logic [DW-1:0] word_b
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Single writer process for both ports; port A is applied last so it
  // wins a same-address collision.
  always_ff @(posedge clk_a or posedge clk_b) begin
    if (wr_go_b) store[addr_b] <= wdata_b;
    if (wr_go_a) store[addr_a] <= wdata_a;
  end

  assign word_a = store[addr_a];
  assign word_b = store[addr_b];

endmodule

// File: rtl/dual_ram_read_stage.sv
module dual_ram_read_stage #(
  parameter int DW         = 9,
  parameter bit FIXED_PIPE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en,
  input  logic          pipe_sel,
  input  logic          rd_act,
  input  logic [DW-1:0] word,
  input  logic          oe,
  output logic [DW-1:0] rdata,
  output logic          drive
);

  logic          use_pipe;
  logic          pipe_vld;
  logic [DW-1:0] pipe_data;

  generate
    if (FIXED_PIPE) begin : g_fixed
      assign use_pipe = 1'b1 | pipe_sel;
    end else begin : g_select
      assign use_pipe = pipe_sel;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_vld  <= 1'b0;
      pipe_data <= '0;
    end else if (en) begin
      pipe_vld <= rd_act;
      if (rd_act) pipe_data <= word;
    end
  end

  assign rdata = use_pipe ? pipe_data : word;
  assign drive = oe && (use_pipe ? pipe_vld : rd_act);

endmodule

// File: rtl/dual_clock_ram.sv
module dual_clock_ram
  import dual_ram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_ni,
  input  logic          en_a,
  input  logic          sel_a,
  input  logic          wr_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  input  logic          oe_a,
  output logic [DW-1:0] rdata_a,
  output logic          drive_a,
  input  logic          en_b,
  input  logic          sel_b,
  input  logic          wr_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  input  logic          oe_b,
  input  logic          pipe_b,
  output logic [DW-1:0] rdata_b,
  output logic          drive_b
);

  ram_op_e       op_qa, op_qb;
  logic [AW-1:0] addr_qa, addr_qb;
  logic [DW-1:0] wdata_qa, wdata_qb;
  logic          wr_go_qa, wr_go_qb;
  logic [DW-1:0] word_a, word_b;

  dual_ram_capture #(.AW(AW), .DW(DW)) cap_a (
    .clk(clk_a), .rst_ni(rst_ni), .en(en_a), .sel(sel_a), .wr(wr_a),
    .addr(addr_a), .wdata(wdata_a),
    .op_q(op_qa), .addr_q(addr_qa), .wdata_q(wdata_qa), .wr_go(wr_go_qa)
  );

  dual_ram_capture #(.AW(AW), .DW(DW)) cap_b (
    .clk(clk_b), .rst_ni(rst_ni), .en(en_b), .sel(sel_b), .wr(wr_b),
    .addr(addr_b), .wdata(wdata_b),
    .op_q(op_qb), .addr_q(addr_qb), .wdata_q(wdata_qb), .wr_go(wr_go_qb)
  );

  dual_ram_array #(.AW(AW), .DW(DW)) core (
    .clk_a(clk_a), .clk_b(clk_b),
    .wr_go_a(wr_go_qa), .addr_a(addr_qa), .wdata_a(wdata_qa),
    .wr_go_b(wr_go_qb), .addr_b(addr_qb), .wdata_b(wdata_qb),
    .word_a(word_a), .word_b(word_b)
  );

  dual_ram_read_stage #(.DW(DW), .FIXED_PIPE(1'b1)) out_a (
    .clk(clk_a), .rst_ni(rst_ni), .en(en_a), .pipe_sel(1'b1),
    .rd_act(op_qa == OP_READ), .word(word_a), .oe(oe_a),
    .rdata(rdata_a), .drive(drive_a)
  );

  dual_ram_read_stage #(.DW(DW), .FIXED_PIPE(1'b0)) out_b (
    .clk(clk_b), .rst_ni(rst_ni), .en(en_b), .pipe_sel(pipe_b),
    .rd_act(op_qb == OP_READ), .word(word_b), .oe(oe_b),
    .rdata(rdata_b), .drive(drive_b)
  );

endmodule

// File: rtl/dual_ram_chk.sv
module dual_ram_chk #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_ni,
  input logic          en_a,
  input logic          sel_a,
  input logic          wr_a,
  input logic          oe_a,
  input logic [DW-1:0] rdata_a,
  input logic          drive_a,
  input logic          en_b,
  input logic          sel_b,
  input logic          wr_b,
  input logic          oe_b,
  input logic          pipe_b,
  input logic          drive_b
);

  // R5
  oe_a_gate_chk: assert property (@(posedge clk_a) disable iff (!rst_ni)
    !oe_a |-> !drive_a);

  // R5
  oe_b_gate_chk: assert property (@(posedge clk_b) disable iff (!rst_ni)
    !oe_b |-> !drive_b);

  // R2
  a_read_latency_chk: assert property (@(posedge clk_a) disable iff (!rst_ni)
    (en_a && sel_a && !wr_a) ##1 en_a |=> (drive_a || !oe_a));

  // R4
  a_freeze_hold_chk: assert property (@(posedge clk_a) disable iff (!rst_ni)
    !en_a |=> $stable(rdata_a));

  // R8
  a_write_quiet_chk: assert property (@(posedge clk_a) disable iff (!rst_ni)
    (en_a && sel_a && wr_a) ##1 en_a |=> !drive_a);

  // R8
  b_flow_write_quiet_chk: assert property (@(posedge clk_b) disable iff (!rst_ni)
    (en_b && sel_b && wr_b && !pipe_b) |=> (!drive_b || pipe_b));

  // R3
  b_flow_latency_chk: assert property (@(posedge clk_b) disable iff (!rst_ni)
    (en_b && sel_b && !wr_b && !pipe_b) ##1 !pipe_b |-> (drive_b || !oe_b));

endmodule

bind dual_clock_ram dual_ram_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dual_clock_ram_test.sv
`timescale 1ns/1ps
module dual_clock_ram_test;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic en_a = 0, sel_a = 0, wr_a = 0, oe_a = 0;
  logic en_b = 0, sel_b = 0, wr_b = 0, oe_b = 0, pipe_b = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] wdata_a = '0, wdata_b = '0;
  logic [DW-1:0] rdata_a, rdata_b;
  logic drive_a, drive_b;

  dual_clock_ram #(.AW(AW), .DW(DW)) uut (
    .clk_a(clk), .clk_b(clk), .rst_ni(rst_ni),
    .en_a(en_a), .sel_a(sel_a), .wr_a(wr_a), .addr_a(addr_a),
    .wdata_a(wdata_a), .oe_a(oe_a), .rdata_a(rdata_a), .drive_a(drive_a),
    .en_b(en_b), .sel_b(sel_b), .wr_b(wr_b), .addr_b(addr_b),
    .wdata_b(wdata_b), .oe_b(oe_b), .pipe_b(pipe_b),
    .rdata_b(rdata_b), .drive_b(drive_b)
  );

  // Reference state, derived from the requirements.
  logic [DW-1:0] mm [N];
  logic [AW-1:0] qa_addr, qb_addr;
  logic [DW-1:0] qa_d, qb_d, pa_d, pb_d;
  logic qa_rd, qb_rd, qa_wgo, qb_wgo, pa_v, pb_v;

  int n_run = 0, n_fail = 0;
  string tag = "R9";
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    qa_addr = '0; qb_addr = '0; qa_d = '0; qb_d = '0; pa_d = '0; pb_d = '0;
    qa_rd = 0; qb_rd = 0; qa_wgo = 0; qb_wgo = 0; pa_v = 0; pb_v = 0;
  endtask

  // One clock edge of the reference: reads see the array before this
  // edge's writes (R6); A's write is applied after B's (R7).
  task automatic model_step();
    logic [DW-1:0] old_a, old_b;
    old_a = mm[qa_addr];
    old_b = mm[qb_addr];
    if (qb_wgo) mm[qb_addr] = qb_d;
    if (qa_wgo) mm[qa_addr] = qa_d;
    if (en_a) begin
      pa_v = qa_rd;
      if (qa_rd) pa_d = old_a;
      qa_addr = addr_a; qa_d = wdata_a;
      qa_rd = sel_a && !wr_a; qa_wgo = sel_a && wr_a;
    end else qa_wgo = 0;
    if (en_b) begin
      pb_v = qb_rd;
      if (qb_rd) pb_d = old_b;
      qb_addr = addr_b; qb_d = wdata_b;
      qb_rd = sel_b && !wr_b; qb_wgo = sel_b && wr_b;
    end else qb_wgo = 0;
  endtask

  task automatic compare();
    bit ea, eb;
    logic [DW-1:0] db;
    ea = oe_a && pa_v;
    chk(drive_a === ea, "drive_a", int'(drive_a), int'(ea));
    if (ea) chk(rdata_a === pa_d, "rdata_a", int'(rdata_a), int'(pa_d));
    if (pipe_b) begin eb = oe_b && pb_v; db = pb_d; end
    else        begin eb = oe_b && qb_rd; db = mm[qb_addr]; end
    chk(drive_b === eb, "drive_b", int'(drive_b), int'(eb));
    if (eb) chk(rdata_b === db, "rdata_b", int'(rdata_b), int'(db));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic pa(input bit e, input bit s, input bit w, input int ad, input int d);
    en_a = e; sel_a = s; wr_a = w; addr_a = AW'(ad); wdata_a = DW'(d);
  endtask

  task automatic pbt(input bit e, input bit s, input bit w, input int ad, input int d);
    en_b = e; sel_b = s; wr_b = w; addr_b = AW'(ad); wdata_b = DW'(d);
  endtask

  task automatic idle(input int n);
    pa(1, 0, 0, 0, 0); pbt(1, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd1977));
    model_reset();
    oe_a = 1; oe_b = 1;
    // R9: drive flags low during reset, even with a read pending
    pa(1, 1, 0, 1, 0); pbt(1, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    tag = "R9";
    chk(drive_a === 1'b0, "drive_a in reset", int'(drive_a), 0);
    chk(drive_b === 1'b0, "drive_b in reset", int'(drive_b), 0);
    pa(1, 0, 0, 0, 0); pbt(1, 0, 0, 0, 0);
    @(negedge clk);
    rst_ni = 1;

    // R1: fill every word through port A, then read back through B (flow)
    tag = "R1";
    for (int i = 0; i < N; i++) begin pa(1, 1, 1, i, i * 37 + 5); cyc(); end
    pa(1, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) begin pbt(1, 1, 0, i, 0); cyc(); end
    idle(2);

    // R3: flow-through latency on B, single read then idle
    tag = "R3";
    pbt(1, 1, 0, 9, 0); cyc();
    pbt(1, 0, 0, 0, 0);
    chk(drive_b === 1'b1, "flow drive one edge after capture", int'(drive_b), 1);
    cyc();
    // R3: pipelined latency on B
    pipe_b = 1; idle(1);
    pbt(1, 1, 0, 9, 0); cyc();
    pbt(1, 0, 0, 0, 0);
    chk(drive_b === 1'b0, "pipe drive not yet", int'(drive_b), 0);
    cyc();
    chk(drive_b === 1'b1, "pipe drive after two edges", int'(drive_b), 1);
    idle(1);

    // R2: A read latency
    tag = "R2";
    pa(1, 1, 0, 4, 0); cyc();
    pa(1, 0, 0, 0, 0);
    chk(drive_a === 1'b0, "A drive not yet", int'(drive_a), 0);
    cyc();
    chk(drive_a === 1'b1, "A drive after two edges", int'(drive_a), 1);
    idle(1);

    // R6: A writes word 3 while B reads it (flow), then B reads again
    tag = "R6"; pipe_b = 0; idle(1);
    pa(1, 1, 1, 3, 9'h155); pbt(1, 1, 0, 3, 0); cyc();
    pa(1, 0, 0, 0, 0); cyc();
    pbt(1, 0, 0, 0, 0); idle(1);
    pbt(1, 1, 0, 3, 0); cyc();
    chk(rdata_b === 9'h155, "new word after collision", int'(rdata_b), 9'h155);
    idle(1);

    // R7: both write word 7, A's data kept
    tag = "R7";
    pa(1, 1, 1, 7, 9'h0F0); pbt(1, 1, 1, 7, 9'h10F); cyc();
    idle(1);
    pbt(1, 1, 0, 7, 0); cyc();
    chk(rdata_b === 9'h0F0, "double write winner", int'(rdata_b), 9'h0F0);
    idle(1);

    // R4: write on A with enable low must not land; outputs held
    tag = "R4";
    pa(1, 1, 0, 2, 0); cyc(); cyc();
    pa(0, 1, 1, 2, 9'h1FF); cyc(); cyc();
    chk(drive_a === 1'b1, "frozen A keeps drive", int'(drive_a), 1);
    pa(1, 0, 0, 0, 0); cyc();
    pbt(1, 1, 0, 2, 0); cyc();
    chk(rdata_b !== 9'h1FF, "frozen write ignored", int'(rdata_b), int'(mm[2]));
    idle(1);

    // R5: output enable gates drive without a clock edge
    tag = "R5";
    pbt(1, 1, 0, 6, 0); cyc();
    pbt(1, 0, 0, 0, 0); en_b = 0;
    #1 oe_b = 0; #0.5;
    chk(drive_b === 1'b0, "oe low releases", int'(drive_b), 0);
    oe_b = 1; #0.5;
    chk(drive_b === 1'b1, "oe high restores", int'(drive_b), 1);
    en_b = 1; cyc(); idle(1);

    // R8: write after read on A: quiet, data held
    tag = "R8";
    pa(1, 1, 0, 8, 0); cyc();
    pa(1, 1, 1, 8, 9'h033); cyc();
    pa(1, 0, 0, 0, 0); cyc();
    chk(drive_a === 1'b0, "A quiet for write", int'(drive_a), 0);
    chk(rdata_a === pa_d, "A data held", int'(rdata_a), int'(pa_d));
    idle(2);

    // R10: random traffic on both ports
    tag = "R10";
    for (int blk = 0; blk < 12; blk++) begin
      pipe_b = $urandom_range(0, 1);
      idle(2);
      for (int i = 0; i < 300; i++) begin
        pa($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, N - 1), $urandom_range(0, 511));
        pbt($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
            $urandom_range(0, N - 1), $urandom_range(0, 511));
        oe_a = $urandom_range(0, 9) != 0;
        oe_b = $urandom_range(0, 9) != 0;
        cyc();
      end
      oe_a = 1; oe_b = 1;
    end
    idle(2);

    done = 1;
    finish_up();
  end
endmodule